// File: doc/BRIEF.md
# Navigation Bit Edge Histogram Synchronizer

This block locates where 20 ms navigation data bits begin within a stream of 1 ms prompt in-phase correlator results. It keeps one transition counter for each of the twenty 1 ms slots in a bit period. It watches the sign of successive samples, and each time the sign flips it charges the slot where the flip happened. Real bit edges fall in the same slot every time, while noise spreads its flips across all of them.

Two programmable limits settle the search. If one slot collects more flips than the high limit, the edge is found and its slot index is reported. If two or more slots climb past the low limit, the data is judged too noisy and the search fails. A clear pulse empties the histogram and starts a new search. The outputs are registered and stay frozen once a verdict is reached.

Top module: `bit_edge_hist`

## Requirements
- R1: After reset or a clear pulse, done, fail and edge_idx read 0 on the next edge, and every slot counter is 0. Clear takes priority over a sample in the same cycle.
- R2: Samples are numbered k = 0, 1, 2, ... from the last clear. A sign flip between sample k-1 and sample k is charged to slot k mod 20, so the slot index wraps from 19 back to 0.
- R3: The first valid sample after a clear only stores its sign and charges no slot.
- R4: The sign is bit IW-1 of the two's-complement in_i. A zero sample counts as positive.
- R5: When a slot count becomes strictly greater than hi_thr, done goes to 1 on that sample's clock edge and edge_idx gives that slot. If several slots qualify, the lowest index is reported.
- R6: When two or more slot counts are strictly greater than lo_thr, fail goes to 1 on that sample's clock edge.
- R7: If the success and failure conditions both hold on the same sample, only fail is set.
- R8: Once done or fail is 1, later samples and threshold changes have no effect. The outputs hold until the next clear.
- R9: Slot counters are CW bits (8 by default) and stop at 255 instead of wrapping.
- R10: Cycles with in_valid low change no state. This includes the slot position and the stored sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empties the histogram and restarts the search |
| in_valid | input | 1 | Marks a new 1 ms prompt I sample |
| in_i | input | IW | Signed prompt I value |
| hi_thr | input | CW | Success limit; a count must be greater than this |
| lo_thr | input | CW | Failure limit; two counts must be greater than this |
| done | output | 1 | Bit edge found |
| fail | output | 1 | Search rejected as ambiguous |
| edge_idx | output | 5 | Slot of the found edge, 0 to 19 |

## Verification
The assertions assume the thresholds stay steady while samples stream in. They also assume a clear is the only way to leave a verdict state. The stimulus changes thresholds only between streams, or on purpose once a histogram is already built up. That is how it gets success and failure on the same sample, and how it exposes a saturated counter. Sign patterns put flips in chosen slots, including slot 0 (after the index wraps) and slot 19. This lets each verdict be worked out by hand from the flip times.

// File: rtl/bit_edge_hist.sv
module bit_edge_hist #(
  parameter int BINS = 20,
  parameter int CW   = 8,
  parameter int IW   = 16,
  localparam int XW  = $clog2(BINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [IW-1:0] in_i,
  input  logic [CW-1:0] hi_thr,
  input  logic [CW-1:0] lo_thr,
  output logic          done,
  output logic          fail,
  output logic [XW-1:0] edge_idx
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [XW-1:0] LAST = XW'(BINS - 1);

  logic [CW-1:0] cnt [BINS];
  logic [CW-1:0] nxt [BINS];
  logic [XW-1:0] pos;
  logic          prev_neg, have_prev;
  logic          hit_any, over1, over2;
  logic [XW-1:0] hit_idx;

  wire neg  = in_i[IW-1];
  wire take = in_valid && !done && !fail;
  wire flip = take && have_prev && (neg != prev_neg);

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    over1   = 1'b0;
    over2   = 1'b0;
    for (int k = 0; k < BINS; k++) begin
      nxt[k] = (flip && pos == XW'(k) && cnt[k] != CMAX) ? cnt[k] + 1'b1 : cnt[k];
      if (!hit_any && nxt[k] > hi_thr) begin
        hit_any = 1'b1;
        hit_idx = XW'(k);
      end
      if (nxt[k] > lo_thr) begin
        if (over1) over2 = 1'b1;
        over1 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < BINS; k++) cnt[k] <= '0;
      pos <= '0; prev_neg <= 1'b0; have_prev <= 1'b0;
      done <= 1'b0; fail <= 1'b0; edge_idx <= '0;
    end else if (clear) begin
      for (int k = 0; k < BINS; k++) cnt[k] <= '0;
      pos <= '0; prev_neg <= 1'b0; have_prev <= 1'b0;
      done <= 1'b0; fail <= 1'b0; edge_idx <= '0;
    end else if (take) begin
      for (int k = 0; k < BINS; k++) cnt[k] <= nxt[k];
      prev_neg  <= neg;
      have_prev <= 1'b1;
      pos       <= (pos == LAST) ? '0 : pos + 1'b1;
      if (over2) fail <= 1'b1;
      else if (hit_any) begin
        done     <= 1'b1;
        edge_idx <= hit_idx;
      end
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> (done && $stable(edge_idx)));
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail);
  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail));
  // R3
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && !have_prev && !done && !fail) |=> (!done && !fail));
  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n) pos <= LAST);
  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!done && !fail && edge_idx == '0));

  for (genvar g = 0; g < BINS; g++) begin : g_sat
    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CMAX && !clear) |=> cnt[g] == CMAX);
  end
endmodule

// File: tb/bit_edge_hist_bench.sv
module bit_edge_hist_bench;
  logic clk = 0, rst_n = 0, clear = 0, in_valid = 0;
  logic signed [15:0] in_i = '0;
  logic [7:0] hi_thr = 8'd255, lo_thr = 8'd255;
  logic done, fail;
  logic [4:0] edge_idx;
  int total = 0, bad = 0;
  logic last_neg = 0;

  always #10 clk = ~clk;

  bit_edge_hist u_bit_edge_hist (.clk, .rst_n, .clear, .in_valid, .in_i,
    .hi_thr, .lo_thr, .done, .fail, .edge_idx);

  // row: slot a, slot b (31 = none), samples, hi, lo, exp done, exp fail, exp idx
  localparam int VEC [5][8] = '{
    '{7, 31, 200, 5, 3, 1, 0, 7},    // R5 R2
    '{0, 31, 200, 5, 3, 1, 0, 0},    // R2 wrap into slot 0
    '{19, 31, 60, 5, 3, 0, 0, 0},    // R5 not yet exceeded
    '{3, 12, 400, 10, 4, 0, 1, 0},   // R6
    '{2, 19, 300, 3, 3, 1, 0, 2}     // R5 then R8 freeze before fail
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic signed [15:0] v);
    @(negedge clk); in_i = v; in_valid = 1;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); in_valid = 0; clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic pattern(input int a, input int b, input int n);
    logic s = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0 && (k % 20 == a || k % 20 == b)) s = !s;
      put(s ? -16'(k % 9 + 1) : 16'(k % 7));
    end
    last_neg = s;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset fail", fail, 0);
    chk("R1 reset idx", edge_idx, 0);

    for (int r = 0; r < 5; r++) begin
      do_clear();
      chk("R1 clear done", done, 0);
      hi_thr = 8'(VEC[r][3]); lo_thr = 8'(VEC[r][4]);
      pattern(VEC[r][0], VEC[r][1], VEC[r][2]);
      chk("R5 table done", done, VEC[r][5]);
      chk("R6 table fail", fail, VEC[r][6]);
      chk("R2 table idx", edge_idx, VEC[r][7]);
    end

    // R3: first sample is negative but charges nothing
    do_clear(); hi_thr = 0; lo_thr = 255;
    put(-4); idle(); chk("R3 first sample", done, 0);
    put(-9); idle(); chk("R3 no flip", done, 0);
    put(6);  idle(); chk("R3 flip done", done, 1);
    chk("R3 flip idx", edge_idx, 2);

    // R4: zero counts as positive
    do_clear();
    put(5); put(0); idle(); chk("R4 zero positive", done, 0);
    put(-1); idle(); chk("R4 flip after zero", done, 1);
    chk("R4 idx", edge_idx, 2);

    // R10: invalid cycles ignored
    do_clear();
    put(5); idle();
    @(negedge clk); in_i = -5;
    @(negedge clk); in_i = 5;
    @(negedge clk); in_i = -5;
    chk("R10 invalid ignored", done, 0);
    put(5); idle(); chk("R10 stored sign kept", done, 0);
    put(-5); idle(); chk("R10 position held", edge_idx, 2);

    // R7: both verdicts on one sample
    do_clear(); hi_thr = 255; lo_thr = 255;
    pattern(3, 12, 100);
    chk("R7 pre fail", fail, 0);
    hi_thr = 2; lo_thr = 2;
    put(last_neg ? -16'sd7 : 16'sd7); idle();
    chk("R7 fail wins", fail, 1);
    chk("R7 no done", done, 0);

    // R8: frozen after verdict
    hi_thr = 255; lo_thr = 255;
    put(-3); put(3); put(-3); idle();
    chk("R8 fail held", fail, 1);
    chk("R8 done still low", done, 0);

    // R9: saturation, then drop hi_thr
    do_clear(); hi_thr = 255; lo_thr = 255;
    pattern(5, 31, 5210);
    chk("R9 no verdict yet", done, 0);
    hi_thr = 200;
    put(last_neg ? -16'sd7 : 16'sd7); idle();
    chk("R9 saturated done", done, 1);
    chk("R9 idx", edge_idx, 5);

    do_clear();
    chk("R1 clear after done", done, 0);
    chk("R1 clear idx", edge_idx, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule